// File: doc/BRIEF.md
# Dual Breakpoint Address Comparator

This block watches the address buses of two processor units, an execution unit (EU) and an instruction-fetch unit (IFU), and stops the processor when either one reaches a programmed address. Each unit has its own 24-bit breakpoint register. A 16-bit host bus loads each register in two writes: one for the upper part and one for the lower part. On every clock cycle the block compares each register with the low 24 bits of the address that the matching unit drives. A match counts only when the unit marks a valid access and the comparator for that unit is enabled.

A counted match moves that unit's flag state machine from `FLAG_IDLE` to `FLAG_HIT`. The flag stays set until the host clears it. The host cannot set a flag. The block holds `halt_req` high for as long as either flag is set. Each flag machine has two states and two transitions. The transition "arm-to-hit" goes from `FLAG_IDLE` to `FLAG_HIT` on a counted match with no clear in the same cycle. The transition "hit-to-idle" goes from `FLAG_HIT` to `FLAG_IDLE` on a clear. In every other case the state holds.

The breakpoint registers are write-only and have no read path. The enable bits and the clear strobes come from a control register outside this block. The block does not decode host addresses. It takes a 2-bit register select.

Top module: `dual_bkpt_cmp`

## Requirements
- R1: After reset, both breakpoint registers are zero, both flags are clear and `halt_req` is low. An enabled unit that makes a valid access at address 0 then sets its flag.
- R2: A write with select code 0 (EU) or 2 (IFU) loads data bits [7:0] into breakpoint bits [23:16]. Data bits [15:8] of that write are ignored.
- R3: A write with select code 1 (EU) or 3 (IFU) loads data bits [15:0] into breakpoint bits [15:0].
- R4: A write to one unit's register leaves the other unit's register unchanged. A write to one half leaves the other half unchanged.
- R5: The compare uses only bus address bits [23:0]. Bus address bits [31:24] have no effect on a match.
- R6: A match counts only in a cycle where the unit's valid input is high. The flag appears on the clock edge after the matching cycle.
- R7: While a unit's enable is low, a match never sets that unit's flag.
- R8: A set flag stays set until its clear input is high at a clock edge. A clear wins over a match in the same cycle. Dropping the enable does not clear a flag.
- R9: `halt_req` is high in exactly the cycles in which at least one flag is set.
- R10: A match on one unit never sets the other unit's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_sel | input | 2 | Register select: 0 EU upper, 1 EU lower, 2 IFU upper, 3 IFU lower |
| host_wr_data | input | 16 | Host write data |
| eu_bus_addr | input | 32 | EU processor bus address |
| eu_bus_valid | input | 1 | EU bus command marks a valid access |
| eu_bkpt_en | input | 1 | EU comparator enable |
| eu_flag_clr | input | 1 | Clear strobe for the EU reached flag |
| ifu_bus_addr | input | 32 | IFU processor bus address |
| ifu_bus_valid | input | 1 | IFU bus command marks a valid access |
| ifu_bkpt_en | input | 1 | IFU comparator enable |
| ifu_flag_clr | input | 1 | Clear strobe for the IFU reached flag |
| eu_bkpt_reached | output | 1 | EU breakpoint-reached flag (sticky) |
| ifu_bkpt_reached | output | 1 | IFU breakpoint-reached flag (sticky) |
| halt_req | output | 1 | Halt request to the processor |

## Verification
A host write changes the breakpoint at the clock edge that samples it, so the new value takes part in a compare from the next cycle on. A match sampled at one edge shows on the reached output one cycle later, and `halt_req` follows the flag in the same cycle with no added register. A clear also acts at the edge that samples it. The bench drives inputs two nanoseconds after a rising edge. Before each edge it lets a behavioural model compute the next state from those inputs. After the edge it compares all three outputs against the model, so each result is checked in the exact cycle it is due.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int N_UNITS  = 2;
    localparam int UNIT_EU  = 0;
    localparam int UNIT_IFU = 1;

    // Per-unit sticky flag machine
    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_HIT  = 1'b1
    } flag_state_e;

    // Host register select: bit 1 picks the unit, bit 0 picks the half (0 = upper)
    typedef enum logic [1:0] {
        SEL_EU_HI  = 2'd0,
        SEL_EU_LO  = 2'd1,
        SEL_IFU_HI = 2'd2,
        SEL_IFU_LO = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
    import bkpt_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int BP_W   = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_sel,
    input  logic [HALF_W-1:0]             wr_data,
    output logic [N_UNITS-1:0][BP_W-1:0]  bp_q
);

    localparam int HI_W = BP_W - HALF_W;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        localparam logic UNIT_BIT = 1'(u);

        logic [HI_W-1:0]   hi_q;
        logic [HALF_W-1:0] lo_q;
        logic              unit_sel;

        assign unit_sel = wr_en && (wr_sel[1] == UNIT_BIT);

        // Upper part: only the low HI_W bits of the host word are kept
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_q <= '0;
            end else if (unit_sel && !wr_sel[0]) begin
                hi_q <= wr_data[HI_W-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q <= '0;
            end else if (unit_sel && wr_sel[0]) begin
                lo_q <= wr_data;
            end
        end

        assign bp_q[u] = {hi_q, lo_q};
    end

endmodule

// File: rtl/bkpt_match.sv
module bkpt_match #(
    parameter int BUS_W = 32,
    parameter int BP_W  = 24
) (
    input  logic [BP_W-1:0]  bp,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic             bus_valid,
    input  logic             enable,
    output logic             hit
);

    logic addr_eq;

    always_comb begin
        addr_eq = (bus_addr[BP_W-1:0] == bp);
        hit     = enable && bus_valid && addr_eq;
    end

endmodule

// File: rtl/bkpt_flag_fsm.sv
module bkpt_flag_fsm
    import bkpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic reached
);

    flag_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: arm-to-hit and hit-to-idle; the clear has priority
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (hit && !clr) state_d = FLAG_HIT;
            FLAG_HIT:  if (clr)         state_d = FLAG_IDLE;
            default:                    state_d = FLAG_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        reached = (state_q == FLAG_HIT);
    end

endmodule

// File: rtl/dual_bkpt_cmp.sv
module dual_bkpt_cmp
    import bkpt_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int BUS_W  = 32,
    parameter int BP_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [1:0]        host_wr_sel,
    input  logic [HALF_W-1:0] host_wr_data,
    input  logic [BUS_W-1:0]  eu_bus_addr,
    input  logic              eu_bus_valid,
    input  logic              eu_bkpt_en,
    input  logic              eu_flag_clr,
    input  logic [BUS_W-1:0]  ifu_bus_addr,
    input  logic              ifu_bus_valid,
    input  logic              ifu_bkpt_en,
    input  logic              ifu_flag_clr,
    output logic              eu_bkpt_reached,
    output logic              ifu_bkpt_reached,
    output logic              halt_req
);

    logic [N_UNITS-1:0][BP_W-1:0]  bp_q;
    logic [N_UNITS-1:0][BUS_W-1:0] addr_a;
    logic [N_UNITS-1:0]            valid_a;
    logic [N_UNITS-1:0]            en_a;
    logic [N_UNITS-1:0]            clr_a;
    logic [N_UNITS-1:0]            hit_a;
    logic [N_UNITS-1:0]            reached_a;

    assign addr_a[UNIT_EU]   = eu_bus_addr;
    assign addr_a[UNIT_IFU]  = ifu_bus_addr;
    assign valid_a[UNIT_EU]  = eu_bus_valid;
    assign valid_a[UNIT_IFU] = ifu_bus_valid;
    assign en_a[UNIT_EU]     = eu_bkpt_en;
    assign en_a[UNIT_IFU]    = ifu_bkpt_en;
    assign clr_a[UNIT_EU]    = eu_flag_clr;
    assign clr_a[UNIT_IFU]   = ifu_flag_clr;

    bkpt_regfile #(
        .HALF_W (HALF_W),
        .BP_W   (BP_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr_en),
        .wr_sel  (host_wr_sel),
        .wr_data (host_wr_data),
        .bp_q    (bp_q)
    );

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        bkpt_match #(
            .BUS_W (BUS_W),
            .BP_W  (BP_W)
        ) u_match (
            .bp        (bp_q[u]),
            .bus_addr  (addr_a[u]),
            .bus_valid (valid_a[u]),
            .enable    (en_a[u]),
            .hit       (hit_a[u])
        );

        bkpt_flag_fsm u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit_a[u]),
            .clr     (clr_a[u]),
            .reached (reached_a[u])
        );
    end

    assign eu_bkpt_reached  = reached_a[UNIT_EU];
    assign ifu_bkpt_reached = reached_a[UNIT_IFU];
    assign halt_req         = |reached_a;

endmodule

// File: rtl/bkpt_checker.sv
module bkpt_checker #(
    parameter int HALF_W = 16,
    parameter int BUS_W  = 32,
    parameter int BP_W   = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [HALF_W-1:0] wr_data,
    input logic [BP_W-1:0]   bp_eu,
    input logic [BP_W-1:0]   bp_ifu,
    input logic [BUS_W-1:0]  eu_addr,
    input logic              eu_valid,
    input logic              eu_en,
    input logic              eu_clr,
    input logic [BUS_W-1:0]  ifu_addr,
    input logic              ifu_valid,
    input logic              ifu_en,
    input logic              ifu_clr,
    input logic              eu_r,
    input logic              ifu_r,
    input logic              halt
);

    localparam int HI_W = BP_W - HALF_W;

    logic [1:0]            r_a, en_a, va_a, clr_a;
    logic [1:0][BP_W-1:0]  bp_a;
    logic [1:0][BUS_W-1:0] ad_a;

    assign r_a   = {ifu_r, eu_r};
    assign en_a  = {ifu_en, eu_en};
    assign va_a  = {ifu_valid, eu_valid};
    assign clr_a = {ifu_clr, eu_clr};
    assign bp_a  = {bp_ifu, bp_eu};
    assign ad_a  = {ifu_addr, eu_addr};

    for (genvar u = 0; u < 2; u++) begin : g_chk
        localparam logic UB = 1'(u);

        assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (r_a[u] && !clr_a[u]) |=> r_a[u]);

        assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            clr_a[u] |=> !r_a[u]);

        assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!r_a[u] && !en_a[u]) |=> !r_a[u]);

        assert_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!r_a[u] && !va_a[u]) |=> !r_a[u]);

        assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!r_a[u] && en_a[u] && va_a[u] && !clr_a[u]
             && ad_a[u][BP_W-1:0] == bp_a[u]) |=> r_a[u]);

        assert_hi_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == {UB, 1'b0})
            |=> bp_a[u][BP_W-1:HALF_W] == $past(wr_data[HI_W-1:0]));

        assert_lo_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == {UB, 1'b1})
            |=> bp_a[u][HALF_W-1:0] == $past(wr_data));

        assert_other_unit_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel[1] != UB) |=> $stable(bp_a[u]));
    end

    assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt == (eu_r || ifu_r));

endmodule

bind dual_bkpt_cmp bkpt_checker #(
    .HALF_W (HALF_W),
    .BUS_W  (BUS_W),
    .BP_W   (BP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (host_wr_en),
    .wr_sel    (host_wr_sel),
    .wr_data   (host_wr_data),
    .bp_eu     (bp_q[0]),
    .bp_ifu    (bp_q[1]),
    .eu_addr   (eu_bus_addr),
    .eu_valid  (eu_bus_valid),
    .eu_en     (eu_bkpt_en),
    .eu_clr    (eu_flag_clr),
    .ifu_addr  (ifu_bus_addr),
    .ifu_valid (ifu_bus_valid),
    .ifu_en    (ifu_bkpt_en),
    .ifu_clr   (ifu_flag_clr),
    .eu_r      (eu_bkpt_reached),
    .ifu_r     (ifu_bkpt_reached),
    .halt      (halt_req)
);

// File: tb/dual_bkpt_cmp_test.sv
module dual_bkpt_cmp_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [1:0]  host_wr_sel = 2'd0;
    logic [15:0] host_wr_data = 16'd0;
    logic [31:0] eu_bus_addr = 32'd0;
    logic        eu_bus_valid = 1'b0;
    logic        eu_bkpt_en = 1'b0;
    logic        eu_flag_clr = 1'b0;
    logic [31:0] ifu_bus_addr = 32'd0;
    logic        ifu_bus_valid = 1'b0;
    logic        ifu_bkpt_en = 1'b0;
    logic        ifu_flag_clr = 1'b0;
    logic        eu_bkpt_reached, ifu_bkpt_reached, halt_req;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state
    logic [23:0] m_bp [2];
    logic        m_flag [2];

    always #10 clk = ~clk;   // 50 MHz

    dual_bkpt_cmp uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .host_wr_en       (host_wr_en),
        .host_wr_sel      (host_wr_sel),
        .host_wr_data     (host_wr_data),
        .eu_bus_addr      (eu_bus_addr),
        .eu_bus_valid     (eu_bus_valid),
        .eu_bkpt_en       (eu_bkpt_en),
        .eu_flag_clr      (eu_flag_clr),
        .ifu_bus_addr     (ifu_bus_addr),
        .ifu_bus_valid    (ifu_bus_valid),
        .ifu_bkpt_en      (ifu_bkpt_en),
        .ifu_flag_clr     (ifu_flag_clr),
        .eu_bkpt_reached  (eu_bkpt_reached),
        .ifu_bkpt_reached (ifu_bkpt_reached),
        .halt_req         (halt_req)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: model computes the next state from the inputs now applied,
    // the edge happens, then all outputs are compared against the model.
    task automatic tick(input string tag);
        logic [23:0] nbp [2];
        logic        nfl [2];
        logic [31:0] ad [2];
        logic        va [2], en [2], cl [2];
        ad[0] = eu_bus_addr;  ad[1] = ifu_bus_addr;
        va[0] = eu_bus_valid; va[1] = ifu_bus_valid;
        en[0] = eu_bkpt_en;   en[1] = ifu_bkpt_en;
        cl[0] = eu_flag_clr;  cl[1] = ifu_flag_clr;
        for (int u = 0; u < 2; u++) begin
            nbp[u] = m_bp[u];
            if (host_wr_en && int'(host_wr_sel[1]) == u) begin
                if (host_wr_sel[0]) nbp[u][15:0]  = host_wr_data;
                else                nbp[u][23:16] = host_wr_data[7:0];
            end
            if (cl[u])          nfl[u] = 1'b0;
            else if (m_flag[u]) nfl[u] = 1'b1;
            else                nfl[u] = en[u] && va[u] && (ad[u][23:0] == m_bp[u]);
            if (!rst_n) begin
                nbp[u] = 24'd0;
                nfl[u] = 1'b0;
            end
        end
        @(posedge clk);
        #2;
        for (int u = 0; u < 2; u++) begin
            m_bp[u]   = nbp[u];
            m_flag[u] = nfl[u];
        end
        check(tag, "eu_bkpt_reached",  eu_bkpt_reached,  m_flag[0]);
        check(tag, "ifu_bkpt_reached", ifu_bkpt_reached, m_flag[1]);
        check(tag, "halt_req",         halt_req,         m_flag[0] | m_flag[1]);
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [15:0] data, input string tag);
        host_wr_en   = 1'b1;
        host_wr_sel  = sel;
        host_wr_data = data;
        tick(tag);
        host_wr_en   = 1'b0;
    endtask

    task automatic clear_both(input string tag);
        eu_flag_clr  = 1'b1;
        ifu_flag_clr = 1'b1;
        tick(tag);
        eu_flag_clr  = 1'b0;
        ifu_flag_clr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_bp[0] = 24'd0; m_bp[1] = 24'd0;
        m_flag[0] = 1'b0; m_flag[1] = 1'b0;

        // R1: reset state
        repeat (3) tick("R1");
        rst_n = 1'b1;
        tick("R1");

        // R1: reset value 0 is a live breakpoint once enabled
        eu_bkpt_en = 1'b1; eu_bus_valid = 1'b1; eu_bus_addr = 32'd0;
        tick("R1");
        eu_bus_valid = 1'b0;
        tick("R1");
        clear_both("R8");

        // R2/R3: load EU = 0x123456 with junk in the dropped byte
        host_write(2'd0, 16'hAB12, "R2");
        host_write(2'd1, 16'h3456, "R3");

        // R5: a near miss, then a match with junk in bus bits [31:24]
        eu_bus_valid = 1'b1; eu_bus_addr = 32'h0012_3457;
        tick("R5");
        eu_bus_addr = 32'hFF12_3456;
        tick("R5");
        tick("R8");
        eu_bus_valid = 1'b0;
        clear_both("R8");

        // R6: a matching address without a valid access
        eu_bus_addr = 32'h0012_3456;
        repeat (2) tick("R6");

        // R7: a disabled comparator ignores a valid match
        eu_bkpt_en = 1'b0; eu_bus_valid = 1'b1;
        repeat (2) tick("R7");

        // R8: clear wins over a persisting match, then the match re-sets
        eu_bkpt_en = 1'b1;
        tick("R8");
        eu_flag_clr = 1'b1;
        tick("R8");
        eu_flag_clr = 1'b0;
        tick("R8");
        // R8: dropping the enable keeps the flag
        eu_bkpt_en = 1'b0; eu_bus_valid = 1'b0;
        repeat (2) tick("R8");
        clear_both("R8");

        // R4: load IFU = 0x00BEEF; EU register must stay 0x123456
        host_write(2'd2, 16'h5500, "R4");
        host_write(2'd3, 16'hBEEF, "R4");
        // R4: rewrite only the EU upper half; lower half stays 0x3456
        host_write(2'd0, 16'h0077, "R4");
        eu_bkpt_en = 1'b1; eu_bus_valid = 1'b1; eu_bus_addr = 32'h0077_3456;
        tick("R4");

        // R10: EU hit alone leaves IFU clear, even with an IFU near miss
        ifu_bkpt_en = 1'b1; ifu_bus_valid = 1'b1; ifu_bus_addr = 32'h0012_3456;
        tick("R10");

        // R9: both flags set, clear one, halt stays
        ifu_bus_addr = 32'h4400_BEEF;
        tick("R9");
        eu_bus_valid = 1'b0; ifu_bus_valid = 1'b0;
        eu_flag_clr = 1'b1;
        tick("R9");
        eu_flag_clr = 1'b0;
        tick("R9");
        ifu_flag_clr = 1'b1;
        tick("R9");
        ifu_flag_clr = 1'b0;
        tick("R9");

        // R2: an IFU upper-half rewrite takes effect on the next compare
        host_write(2'd2, 16'hFF01, "R2");
        ifu_bus_valid = 1'b1; ifu_bus_addr = 32'h0000_BEEF;
        tick("R2");
        ifu_bus_addr = 32'h0001_BEEF;
        tick("R2");
        tick("R2");
        ifu_bus_valid = 1'b0;
        clear_both("R8");

        // R1: reset in mid-run clears flags and registers
        ifu_bus_valid = 1'b1;
        tick("R1");
        rst_n = 1'b0;
        tick("R1");
        rst_n = 1'b1;
        ifu_bus_addr = 32'h0000_0000;
        tick("R1");
        tick("R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule